// File: doc/BRIEF.md
# External Interrupt Pin Edge Detector

This block watches one external interrupt pin and holds a sticky request flag. The flag is raised when the pin shows the edge selected in a 4-bit control register. Software reaches the register through a 4-bit write port and a 4-bit read port, which are driven by register-transfer instructions. Software clears the flag with a one-cycle strobe.

The pin first passes through a flop synchroniser. The design then folds the synchronised level with the polarity bit into an "active-level" sample. A rising step of that sample is a selected edge. Any step of it counts when both-edge mode is on. The same active-level sample gives two things:
- a level-test output, used by the pin-test instruction;
- a return-level match for the power-down wake-up sequencer.

Because the polarity bit enters that fold, rewriting the polarity can look like an edge and raise the flag. Software clears the flag after such a change. Control bit 0 is passed through as an enable for the pin's control role in timer 1. Bit 3 is plain storage.

Top module: `extint_edge_ctrl`

## Requirements
- R1: After reset the control register reads 0000, `req_flag` is 0, `timer_gate_en` is 0 and the register is set for falling-edge, single-edge operation.
- R2: A cycle with `wr_en` high stores `wdata` into the control register at that clock edge, including bit 3, which has no function. `rdata` shows the register while `rd_en` is high and reads 0000 otherwise.
- R3: `timer_gate_en` equals control bit 0, which is updated by the write edge.
- R4: With bit 2 = 0 and bit 1 = 0, a high-to-low pin change sets `req_flag` on the third rising clock edge after the change, and a low-to-high change does not set it.
- R5: With bit 2 = 1 and bit 1 = 0, a low-to-high pin change sets `req_flag` and a high-to-low change does not.
- R6: With bit 1 = 1, both pin directions set `req_flag` for either value of bit 2.
- R7: `level_match` is 1 when the synchronised pin equals bit 2 (0 = low level, 1 = high level). It reflects a pin change from the second rising clock edge after that change.
- R8: `req_flag` stays 1 until a cycle with `flag_clr` high and no detection, which clears it at that edge.
- R9: When `flag_clr` and a detection fall in the same cycle, `req_flag` is 1 after that edge.
- R10: Writing a new value of bit 2 is treated as an edge of the active-level sample, with the detection cycle directly after the write edge:
  - in single-edge mode the flag is set when the steady pin already sits at the new active level, and is not set otherwise;
  - in both-edge mode any change of bit 2 under a steady pin sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| wr_en | input | 1 | One-cycle register write strobe |
| wdata | input | 4 | Register write data |
| rd_en | input | 1 | Register read select |
| rdata | output | 4 | Register read data (0000 when not selected) |
| flag_clr | input | 1 | One-cycle request flag clear strobe |
| req_flag | output | 1 | Sticky interrupt request flag |
| level_match | output | 1 | Synchronised pin sits at the level chosen by bit 2 |
| timer_gate_en | output | 1 | Pin-controls-timer-1 enable (control bit 0) |

## Verification
A wrong stored previous sample or a wrong polarity fold shows up as the flag rising on the wrong pin direction. It can also show as the flag staying low on the right one. Either way it is visible on `req_flag` three clock edges after the pin moves. A register that misses the write or drops bit 3 shows on `rdata` in the cycle right after the write edge. A flag with the wrong set/clear priority shows up as `req_flag` reading 0 after a clear strobe that coincided with a detection. A broken apparent-edge path shows as the flag staying low one edge after a polarity rewrite.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int CTRL_W    = 4;
  localparam int TMR_BIT   = 0;
  localparam int BOTH_BIT  = 1;
  localparam int POL_BIT   = 2;
  localparam int SPARE_BIT = 3;

  typedef struct packed {
    logic spare;
    logic pol;
    logic both;
    logic tmr_en;
  } ctrl_t;

  // Fold the pin with the polarity: 1 means "pin at the active level".
  function automatic logic active_level(input logic pin, input logic pol);
    return pol ? pin : ~pin;
  endfunction

  // Detection on the folded sample: a rising step, or any step in both mode.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic both);
    return both ? (cur ^ prev) : (cur & ~prev);
  endfunction

  // Flag next state: a set beats a clear.
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/extint_ctrl_reg.sv
module extint_ctrl_reg
  import extint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              rd_en,
  output logic [CTRL_W-1:0] rdata,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_t'(wdata);
  end

  assign ctrl  = ctrl_q;
  assign rdata = rd_en ? CTRL_W'(ctrl_q) : '0;
endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic pol,
  input  logic both,
  output logic act_now,
  output logic act_prev,
  output logic det
);
  // The current folded sample uses the current polarity. A polarity
  // rewrite therefore looks like a step of the folded sample.
  assign act_now = active_level(pin_s, pol);

  // Reset value matches pin low with falling polarity, so there is no
  // detection in the first cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b1;
    else        act_prev <= act_now;
  end

  assign det = edge_hit(act_now, act_prev, both);
endmodule

// File: rtl/extint_req_flag.sv
module extint_req_flag
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, set, clr);
  end
endmodule

// File: rtl/extint_edge_ctrl.sv
module extint_edge_ctrl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              rd_en,
  output logic [CTRL_W-1:0] rdata,
  input  logic              flag_clr,
  output logic              req_flag,
  output logic              level_match,
  output logic              timer_gate_en
);
  ctrl_t ctrl;
  logic  pin_s;
  logic  act_now;
  logic  act_prev;
  logic  edge_det;

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pin_s)
  );

  extint_ctrl_reg u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .wdata(wdata),
    .rd_en(rd_en),
    .rdata(rdata),
    .ctrl (ctrl)
  );

  extint_edge_det u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_s   (pin_s),
    .pol     (ctrl.pol),
    .both    (ctrl.both),
    .act_now (act_now),
    .act_prev(act_prev),
    .det     (edge_det)
  );

  extint_req_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (edge_det),
    .clr  (flag_clr),
    .flag (req_flag)
  );

  assign level_match   = act_now;
  assign timer_gate_en = ctrl.tmr_en;
endmodule

// File: rtl/extint_edge_chk.sv
module extint_edge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wdata,
  input logic       rd_en,
  input logic [3:0] rdata,
  input logic       flag_clr,
  input logic       req_flag,
  input logic       level_match,
  input logic       timer_gate_en,
  input logic [3:0] ctrl,
  input logic       pin_s,
  input logic       det
);
  AST_EDGE_SETS_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) det |=> req_flag); // R4
  AST_NO_SPURIOUS:     assert property (@(posedge clk) disable iff (!rst_n) (!req_flag && !det) |=> !req_flag); // R4
  AST_SINGLE_ONE_DIR:  assert property (@(posedge clk) disable iff (!rst_n) (!ctrl[1] && det) |-> level_match); // R5
  AST_WRITE_LANDS:     assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> ctrl == $past(wdata)); // R2
  AST_READ_IDLE:       assert property (@(posedge clk) disable iff (!rst_n) !rd_en |-> rdata == 4'b0000); // R2
  AST_TIMER_FOLLOWS:   assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> timer_gate_en == $past(wdata[0])); // R3
  AST_FLAG_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) (req_flag && !flag_clr) |=> req_flag); // R8
  AST_CLR_NO_EDGE:     assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && !det) |=> !req_flag); // R8
  AST_SET_BEATS_CLR:   assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && det) |=> req_flag); // R9
  AST_POL_FLIP_BOTH:   assert property (@(posedge clk) disable iff (!rst_n)
                         (ctrl[1] && (ctrl[2] != $past(ctrl[2])) && $stable(pin_s)) |-> det); // R10
endmodule

bind extint_edge_ctrl extint_edge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wdata        (wdata),
  .rd_en        (rd_en),
  .rdata        (rdata),
  .flag_clr     (flag_clr),
  .req_flag     (req_flag),
  .level_match  (level_match),
  .timer_gate_en(timer_gate_en),
  .ctrl         (ctrl),
  .pin_s        (pin_s),
  .det          (edge_det)
);

// File: tb/extint_edge_ctrl_test.sv
module extint_edge_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wdata = 4'b0000;
  logic       rd_en = 1'b0;
  logic [3:0] rdata;
  logic       flag_clr = 1'b0;
  logic       req_flag;
  logic       level_match;
  logic       timer_gate_en;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  extint_edge_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .flag_clr(flag_clr), .req_flag(req_flag),
    .level_match(level_match), .timer_gate_en(timer_gate_en)
  );

  // Vector: {ctrl[3:0], start pin, end pin, expected flag}
  localparam int NV = 8;
  localparam logic [6:0] VEC [NV] = '{
    {4'b0000, 1'b1, 1'b0, 1'b1},  // R4 falling, single
    {4'b0000, 1'b0, 1'b1, 1'b0},  // R4 rising ignored
    {4'b0100, 1'b0, 1'b1, 1'b1},  // R5 rising, single
    {4'b0100, 1'b1, 1'b0, 1'b0},  // R5 falling ignored
    {4'b0010, 1'b0, 1'b1, 1'b1},  // R6 both, rising
    {4'b0010, 1'b1, 1'b0, 1'b1},  // R6 both, falling
    {4'b0110, 1'b1, 1'b0, 1'b1},  // R6 both, pol 1, falling
    {4'b0110, 1'b0, 1'b0, 1'b0}   // R6 steady pin
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [3:0] v);
    wr_en = 1'b1; wdata = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    tick(2);
    // R1 reset state
    rd_en = 1'b1;
    #0 chk("R1 ctrl", rdata, 4'b0000);
    chk("R1 flag", {3'b0, req_flag}, 4'b0000);
    chk("R1 timer", {3'b0, timer_gate_en}, 4'b0000);
    rst_n = 1'b1;
    tick(3);
    chk("R1 flag after release", {3'b0, req_flag}, 4'b0000);

    // R2 write / read including the spare bit
    write_ctrl(4'b1000);
    chk("R2 readback spare", rdata, 4'b1000);
    rd_en = 1'b0;
    #1 chk("R2 idle read", rdata, 4'b0000);
    rd_en = 1'b1;

    // R3 timer enable
    write_ctrl(4'b0001);
    chk("R3 timer on", {3'b0, timer_gate_en}, 4'b0001);
    write_ctrl(4'b0000);
    chk("R3 timer off", {3'b0, timer_gate_en}, 4'b0000);
    tick(3);
    clear_flag();

    // Vector table R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [3:0] c; logic p0, p1, ef;
      {c, p0, p1, ef} = VEC[i];
      pin_in = p0;
      tick(4);
      write_ctrl(c);
      tick(3);
      clear_flag();
      pin_in = p1;
      tick(4);
      chk($sformatf("R4/R5/R6 vec%0d flag", i), {3'b0, req_flag}, {3'b0, ef});
      chk($sformatf("R7 vec%0d level", i), {3'b0, level_match}, {3'b0, p1 == c[2]});
      clear_flag();
    end

    // R4 / R7 exact timing, falling polarity
    write_ctrl(4'b0000);
    pin_in = 1'b1; tick(4); clear_flag();
    pin_in = 1'b0;
    tick();
    chk("R7 level not yet", {3'b0, level_match}, 4'b0000);
    tick();
    chk("R7 level at 2nd edge", {3'b0, level_match}, 4'b0001);
    chk("R4 flag not yet", {3'b0, req_flag}, 4'b0000);
    tick();
    chk("R4 flag at 3rd edge", {3'b0, req_flag}, 4'b0001);

    // R8 sticky then cleared
    tick(5);
    chk("R8 sticky", {3'b0, req_flag}, 4'b0001);
    clear_flag();
    chk("R8 cleared", {3'b0, req_flag}, 4'b0000);

    // R9 clear coinciding with detection
    pin_in = 1'b1; tick(4); clear_flag();
    pin_in = 1'b0;
    tick(2);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk("R9 set beats clear", {3'b0, req_flag}, 4'b0001);
    clear_flag();

    // R10 polarity rewrite, single mode
    pin_in = 1'b1; tick(4); clear_flag();
    write_ctrl(4'b0100);
    chk("R10 not before detect edge", {3'b0, req_flag}, 4'b0000);
    tick();
    chk("R10 pol 0->1 pin high", {3'b0, req_flag}, 4'b0001);
    pin_in = 1'b0; tick(4); clear_flag();
    write_ctrl(4'b0000); tick();
    chk("R10 pol 1->0 pin low", {3'b0, req_flag}, 4'b0001);
    clear_flag();
    write_ctrl(4'b0100); tick(3);
    chk("R10 pol 0->1 pin low no set", {3'b0, req_flag}, 4'b0000);
    // R10 both mode
    write_ctrl(4'b0110); tick(3); clear_flag();
    write_ctrl(4'b0010); tick();
    chk("R10 both-mode flip", {3'b0, req_flag}, 4'b0001);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule